// File: doc/BRIEF.md
# Overlapping 1101 Serial Pattern Detector

This block watches a serial bit stream, one bit per rising clock edge, and raises its detect output in the same cycle as the final bit of every occurrence of the pattern 1101. Occurrences may overlap: the closing 1 of one match counts as the opening 1 of the next. So the stream 1101101 yields two detections and 1111101 yields one.

Inside is a four-state Mealy machine. One state stands for each useful prefix: nothing, "1", "11 or more ones" and "110". The detect output is formed from the present state and the present input bit, so it is not registered. The two-bit state code is chosen so that the next-state logic reduces to two small product terms and a wire.

Top module: `seq1101_detector`

## Requirements
- R1: A synchronous, active-high reset returns the machine to its idle state at the next rising edge. After the reset is released, a stream prefix seen before the reset cannot complete a match.
- R2: In the idle state an input 0 keeps the machine idle and an input 1 moves it to the "1 seen" state. The output is 0 in both cases.
- R3: In the "1 seen" state an input 0 returns the machine to idle and an input 1 moves it to the "ones seen" state. The output is 0 in both cases.
- R4: In the "ones seen" state an input 1 keeps the machine there, however long the run of ones. An input 0 moves it to the "110 seen" state. The output is 0 in both cases.
- R5: In the "110 seen" state an input 0 returns the machine to idle with output 0. An input 1 moves it to the "1 seen" state and drives the output to 1 in that same cycle.
- R6: The output `hit` is 1 only while the machine is in the "110 seen" state and `din` is 1. It changes with `din` within the cycle, before the clock edge.
- R7: Overlapping matches are all reported. The stream 1101101 gives two detections, on its 4th and 7th bits. The stream 1111101 gives one detection, on its 7th bit.
- R8: For any input stream, `hit` in each cycle equals 1 exactly when the current bit and the three bits before it, taken since the last reset, read 1101 in order of arrival.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the idle state |
| din | input | 1 | Serial input bit, one per clock |
| hit | output | 1 | Mealy detect flag, 1 on the last bit of each 1101 |

## Verification
The detect flag is combinational from the registered state and the current bit. Its result is therefore due in the same cycle as the bit that completes the pattern, zero clock edges after that stimulus. The state change caused by a bit shows up only one edge later, through the response to the next bit. The bench drives each bit just after the falling edge and samples `hit` one nanosecond later, before the next rising edge. In that way every expected value belongs to the bit currently applied and to the state built from all earlier bits.

// File: rtl/seq1101_pkg.sv
package seq1101_pkg;
  localparam int STATE_W = 2;

  // Adjacent codes differ in one bit. Bit 0 always holds the last input bit.
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_ONES = 2'b11,
    ST_TAIL = 2'b10
  } pat_state_t;
endpackage

// File: rtl/seq1101_next_state.sv
module seq1101_next_state
  import seq1101_pkg::*;
(
  input  pat_state_t cur,
  input  logic       din,
  output pat_state_t nxt
);
  logic [STATE_W-1:0] c;
  logic [STATE_W-1:0] n;

  assign c = cur;
  // High bit: stay among the two upper codes on a 1, or leave either upper code on a 0.
  assign n[1] = (c[1] & c[0]) | (din & c[0]);
  // Low bit is simply the bit just received.
  assign n[0] = din;
  assign nxt  = pat_state_t'(n);
endmodule

// File: rtl/seq1101_state_reg.sv
module seq1101_state_reg
  import seq1101_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pat_state_t nxt,
  output pat_state_t cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= ST_IDLE;
    else     cur <= nxt;
  end
endmodule

// File: rtl/seq1101_output.sv
module seq1101_output
  import seq1101_pkg::*;
(
  input  pat_state_t cur,
  input  logic       din,
  output logic       hit
);
  logic [STATE_W-1:0] c;
  assign c   = cur;
  assign hit = din & c[1] & ~c[0];
endmodule

// File: rtl/seq1101_detector.sv
module seq1101_detector
  import seq1101_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  pat_state_t state;
  pat_state_t state_nxt;

  seq1101_next_state u_next (
    .cur (state),
    .din (din),
    .nxt (state_nxt)
  );

  seq1101_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (state_nxt),
    .cur (state)
  );

  seq1101_output u_out (
    .cur (state),
    .din (din),
    .hit (hit)
  );

  // R1: reset lands in idle
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> state == ST_IDLE);

  // R2: idle steps
  p_idle_step_r2: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE |=> state == ($past(din) ? ST_ONE : ST_IDLE));

  // R3: one-seen steps
  p_one_step_r3: assert property (@(posedge clk) disable iff (rst)
    state == ST_ONE |=> state == ($past(din) ? ST_ONES : ST_IDLE));

  // R4: a run of ones holds the state
  p_ones_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ONES && din) |=> state == ST_ONES);

  // R5: tail state exits
  p_tail_exit_r5: assert property (@(posedge clk) disable iff (rst)
    state == ST_TAIL |=> state == ($past(din) ? ST_ONE : ST_IDLE));

  // R6: a hit is only possible after "ones" followed by a 0
  p_hit_prefix_r6: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(state) == ST_ONES && !$past(din)));

  // R6: a hit is always followed by the one-seen state
  p_hit_then_one_r6: assert property (@(posedge clk) disable iff (rst)
    hit |=> state == ST_ONE);
endmodule

// File: tb/sim_seq1101_detector.sv
module sim_seq1101_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  seq1101_detector u0 (
    .clk (clk),
    .rst (rst),
    .din (din),
    .hit (hit)
  );

  // Each entry is {rst, din, expected hit}.
  localparam int NVEC = 31;
  localparam logic [2:0] VEC [NVEC] = '{
    3'b100, 3'b100,                                  // reset
    3'b010, 3'b010, 3'b000, 3'b011,                  // 1101    (R7 first)
    3'b010, 3'b000, 3'b011,                          // 101     (R7 second, overlap)
    3'b000,                                          // back to idle
    3'b010, 3'b010, 3'b010, 3'b010, 3'b010, 3'b000, 3'b011, // 1111101 (R7)
    3'b000,
    3'b010, 3'b010, 3'b000,                          // 110 -> tail state
    3'b100,                                          // reset with din=0
    3'b010,                                          // 1 after reset: no hit (R1)
    3'b000, 3'b010,                                  // 0,1 : B->A->B (R3)
    3'b010, 3'b000, 3'b011,                          // 101 completes 1101
    3'b010, 3'b000, 3'b000                           // 1,0,0
  };

  task automatic check(input logic exp, input string req);
    n_checks++;
    if (hit !== exp) begin
      n_fail++;
      $display("FAIL %s: hit=%b expected %b at %0t", req, hit, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic d, input logic exp, input string req);
    @(negedge clk);
    rst = r;
    din = d;
    #1;
    check(exp, req);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    logic [2:0] hist;

    // Table walk: R7 overlap streams, R1 reset, R3 B-state exit
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][2], VEC[i][1], VEC[i][0], "R7/R1 table");
    end

    // R4: long run of ones then 01
    step(1'b1, 1'b0, 1'b0, "R1 reset");
    for (int i = 0; i < 9; i++) step(1'b0, 1'b1, 1'b0, "R4 run of ones");
    step(1'b0, 1'b0, 1'b0, "R4 zero after ones");
    step(1'b0, 1'b1, 1'b1, "R4 match after long run");

    // R5: tail state then 0 goes idle, next 1 no hit
    step(1'b0, 1'b1, 1'b0, "R5 setup");
    step(1'b0, 1'b0, 1'b0, "R5 setup");
    step(1'b0, 1'b0, 1'b0, "R5 tail exit on 0");
    step(1'b0, 1'b1, 1'b0, "R5 no hit from idle");

    // R2: zeros in idle then 1
    step(1'b1, 1'b0, 1'b0, "R1 reset");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, "R2 idle stays");
    step(1'b0, 1'b1, 1'b0, "R2 idle to one");
    step(1'b0, 1'b0, 1'b0, "R2/R3 one to idle");

    // R6: hit follows din within the cycle in tail state
    step(1'b1, 1'b0, 1'b0, "R1 reset");
    step(1'b0, 1'b1, 1'b0, "R6 setup");
    step(1'b0, 1'b1, 1'b0, "R6 setup");
    step(1'b0, 1'b0, 1'b0, "R6 tail, din=0");
    @(negedge clk);
    din = 1'b0;
    #1;
    check(1'b0, "R6 tail din=0 no hit");
    din = 1'b1;
    #1;
    check(1'b1, "R6 tail din=1 hit same cycle");
    din = 1'b0;
    #1;
    check(1'b0, "R6 hit follows din");

    // R8: random stream against a sliding window
    step(1'b1, 1'b0, 1'b0, "R1 reset");
    hist = 3'b000;
    for (int i = 0; i < 2000; i++) begin
      logic b;
      logic e;
      b = 1'($urandom_range(0, 1));
      e = ({hist, b} == 4'b1101);
      step(1'b0, b, e, "R8 random window");
      hist = {hist[1:0], b};
    end

    summary();
  end
endmodule